// File: doc/BRIEF.md
# Debug Bridge Command Engine

This block sits behind an 11-bit debug data register and lets a host probe or load a processor's memory, write its control registers, stop it, restart it and exchange console bytes with it. Every host write to the register reaches the engine as a one-cycle strobe that is already in the system clock domain. The low three bits of the write choose a channel and the upper eight bits carry a payload byte.

Channel 0 carries a byte-serial command stream. A command byte puts its opcode in the upper nibble and may be followed by address, value or data bytes. The parser turns each finished command into one of four actions: a single-byte bus access, a one-cycle control-register strobe, a break pulse or a reset pulse. Channel 1 sends a console byte to the target. Channel 2 acknowledges a console byte received from the target. Reading the register returns a data byte and three flags. The host polls these flags before it moves on.

Bus accesses use a byte-wide request/acknowledge master. An internal address pointer steps by one after every completed access, so sequential bytes can be streamed without resending the address.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset `host_rdata` is all zero, and `mem_req`, `con_tx_valid`, `csr_stb`, `brk_pulse` and `rst_pulse` are low.
- R2: Opcode 1 (command byte 0x10 on channel 0) followed by four address bytes, most significant first, raises `mem_req` with `mem_we` low at that address. Readback bit 2 (busy) is high from the cycle after the last byte until the cycle after `mem_ack`. After that, readback bits [10:3] hold the byte that was read.
- R3: Opcode 2 (0x20) followed by four address bytes and one data byte issues a write of that byte (`mem_we` high). A write leaves the returned data byte unchanged.
- R4: Opcode 3 (0x30, read-next) and opcode 4 (0x40 plus one data byte, write-next) access the address one above the last completed access.
- R5: Opcode 5 (0x50) followed by four value bytes, most significant first, and then an index byte gives exactly one `csr_stb` cycle. The index is the low five bits of the index byte, and the value is carried on `csr_val`.
- R6: Opcode 6 (0x60) gives one `brk_pulse` cycle, and opcode 7 (0x70) gives one `rst_pulse` cycle.
- R7: Channel-0 writes are ignored while busy is high.
- R8: Readback bit 1 is the transmit flag. A channel-1 write while the flag is low loads the payload onto `con_tx_data` and raises `con_tx_valid`, which holds until `con_tx_ready`. A channel-1 write while the flag is high is ignored.
- R9: When no byte is held, an offered receive byte is taken (`con_rx_pop`). Readback bit 0 then goes high and the byte appears in bits [10:3]. A channel-2 write clears bit 0, after which the next byte can be taken.
- R10: While bit 0 is high, bits [10:3] show the received byte, even if a bus read completes in the same cycle. Once bit 0 is cleared, the last bus byte returns.
- R11: In idle, opcode 0 and opcodes 8 to 15 do nothing. A sequence that was cut short is completed by zero bytes, after which further zero bytes are no-ops and a new command is accepted.
- R12: Writes on channels 3 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle strobe of a host register write |
| host_wdata | input | 11 | Payload [10:3], channel [2:0] |
| host_rdata | output | 11 | Data byte [10:3], busy [2], tx flag [1], rx flag [0] |
| mem_req | output | 1 | Bus request, held until acknowledge |
| mem_we | output | 1 | Bus write enable |
| mem_addr | output | AW | Bus byte address |
| mem_wdata | output | 8 | Bus write byte |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | 8 | Bus read byte, valid with acknowledge |
| csr_stb | output | 1 | Control-register write strobe |
| csr_idx | output | IW | Control-register index |
| csr_val | output | VW | Control-register value |
| brk_pulse | output | 1 | Break request pulse |
| rst_pulse | output | 1 | Processor reset request pulse |
| con_tx_valid | output | 1 | Console byte to target is pending |
| con_tx_data | output | 8 | Console byte to target |
| con_tx_ready | input | 1 | Target accepts the console byte |
| con_rx_valid | input | 1 | Target offers a console byte |
| con_rx_data | input | 8 | Console byte from target |
| con_rx_pop | output | 1 | Offered byte is taken this cycle |

## Verification
Two events can land in the same cycle and both update the readback data field: a bus read acknowledge and the capture of a received console byte. The bench provokes this by making its memory responder push a console byte at the moment it raises the acknowledge. It then expects the received byte, with bit 0 set and busy clear. After a channel-2 acknowledge it expects the bus byte to show again. Every other cycle is compared against a behavioural model that builds commands from a byte queue.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int AW = 32,
  parameter int VW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [10:0]   host_wdata,
  output logic [10:0]   host_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          csr_stb,
  output logic [IW-1:0] csr_idx,
  output logic [VW-1:0] csr_val,
  output logic          brk_pulse,
  output logic          rst_pulse,
  output logic          con_tx_valid,
  output logic [7:0]    con_tx_data,
  input  logic          con_tx_ready,
  input  logic          con_rx_valid,
  input  logic [7:0]    con_rx_data,
  output logic          con_rx_pop
);
  localparam int NAB  = AW / 8;
  localparam int NVB  = VW / 8;
  localparam int CNTW = $clog2((NAB > NVB ? NAB : NVB) + 1);
  localparam logic [CNTW-1:0] LAST_A = CNTW'(NAB - 1);
  localparam logic [CNTW-1:0] LAST_V = CNTW'(NVB - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WDAT, S_CVAL, S_CNUM, S_MEM} st_t;

  st_t            st;
  logic [CNTW-1:0] cnt;
  logic           wr_op, txb, rxf;
  logic [AW-1:0]  addr;
  logic [VW-1:0]  cval;
  logic [7:0]     wdat, mbyte, txd, rxd;

  wire [2:0] ch   = host_wdata[2:0];
  wire [7:0] pl   = host_wdata[10:3];
  wire       busy = (st == S_MEM);
  wire       c0   = host_wr && ch == 3'd0 && !busy;

  assign mem_req      = busy;
  assign mem_we       = wr_op;
  assign mem_addr     = addr;
  assign mem_wdata    = wdat;
  assign csr_val      = cval;
  assign con_tx_valid = txb;
  assign con_tx_data  = txd;
  assign con_rx_pop   = !rxf && con_rx_valid;
  assign host_rdata   = {rxf ? rxd : mbyte, busy, txb, rxf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wr_op <= 1'b0; addr <= '0; cval <= '0;
      wdat <= '0; mbyte <= '0; csr_stb <= 1'b0; csr_idx <= '0;
      brk_pulse <= 1'b0; rst_pulse <= 1'b0;
    end else begin
      csr_stb <= 1'b0; brk_pulse <= 1'b0; rst_pulse <= 1'b0;
      case (st)
        S_IDLE: if (c0) begin
          cnt <= '0;
          case (pl[7:4])
            4'd1: begin wr_op <= 1'b0; st <= S_ADDR; end
            4'd2: begin wr_op <= 1'b1; st <= S_ADDR; end
            4'd3: begin wr_op <= 1'b0; st <= S_MEM; end
            4'd4: begin wr_op <= 1'b1; st <= S_WDAT; end
            4'd5: st <= S_CVAL;
            4'd6: brk_pulse <= 1'b1;
            4'd7: rst_pulse <= 1'b1;
            default: ;
          endcase
        end
        S_ADDR: if (c0) begin
          addr <= {addr[AW-9:0], pl};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST_A) st <= wr_op ? S_WDAT : S_MEM;
        end
        S_WDAT: if (c0) begin wdat <= pl; st <= S_MEM; end
        S_CVAL: if (c0) begin
          cval <= {cval[VW-9:0], pl};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST_V) st <= S_CNUM;
        end
        S_CNUM: if (c0) begin csr_stb <= 1'b1; csr_idx <= pl[IW-1:0]; st <= S_IDLE; end
        S_MEM: if (mem_ack) begin
          if (!wr_op) mbyte <= mem_rdata;
          addr <= addr + 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txb <= 1'b0; txd <= '0; rxf <= 1'b0; rxd <= '0;
    end else begin
      if (!txb && host_wr && ch == 3'd1) begin txb <= 1'b1; txd <= pl; end
      else if (txb && con_tx_ready) txb <= 1'b0;
      if (con_rx_pop) begin rxf <= 1'b1; rxd <= con_rx_data; end
      else if (rxf && host_wr && ch == 3'd2) rxf <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_ACK_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req && !host_rdata[2]); // R2
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && host_wr && host_wdata[2:0] == 3'd0 |=> mem_req && !brk_pulse && !rst_pulse && !csr_stb); // R7
  AST_CSR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_stb && !host_wr |=> !csr_stb); // R5
  AST_BRK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse && !host_wr |=> !brk_pulse); // R6
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse && !host_wr |=> !rst_pulse); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    con_tx_valid && !con_tx_ready |=> con_tx_valid && $stable(con_tx_data)); // R8
  AST_RX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    con_rx_pop |=> host_rdata[0] && host_rdata[10:3] == $past(con_rx_data)); // R9
endmodule

// File: tb/dbg_cmd_engine_tb_top.sv
`timescale 1ns/100ps
module dbg_cmd_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [10:0] host_wdata = '0;
  logic [10:0] host_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic csr_stb, brk_pulse, rst_pulse;
  logic [4:0] csr_idx;
  logic [31:0] csr_val;
  logic con_tx_valid, con_tx_ready = 1'b0, con_rx_valid = 1'b0, con_rx_pop;
  logic [7:0] con_tx_data, con_rx_data = '0;

  always #2.5 clk = ~clk;

  dbg_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .csr_stb(csr_stb), .csr_idx(csr_idx), .csr_val(csr_val),
    .brk_pulse(brk_pulse), .rst_pulse(rst_pulse),
    .con_tx_valid(con_tx_valid), .con_tx_data(con_tx_data), .con_tx_ready(con_tx_ready),
    .con_rx_valid(con_rx_valid), .con_rx_data(con_rx_data), .con_rx_pop(con_rx_pop));

  int nchk = 0, nfail = 0;
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // environment: memory responder and console source
  int ack_delay = 2, wc = 0;
  int inj_req = 0, inj_done = 0, ackinj_req = 0, ackinj_done = 0;
  logic [7:0] inj_byte = '0;
  logic [7:0] rxq[$];
  logic req_s, ack_s, pop_s;
  always @(posedge clk) begin
    req_s = mem_req; ack_s = mem_ack; pop_s = con_rx_pop;
    #1;
    if (ack_s) mem_ack = 1'b0;
    else if (req_s) begin
      if (wc >= ack_delay) begin
        mem_ack = 1'b1; mem_rdata = mem_addr[7:0] ^ 8'hA5; wc = 0;
        if (ackinj_done < ackinj_req) begin rxq.push_back(8'hC3); ackinj_done++; end
      end else wc++;
    end
    if (pop_s && rxq.size() > 0) void'(rxq.pop_front());
    if (inj_done < inj_req) begin rxq.push_back(inj_byte); inj_done++; end
    con_rx_valid = rxq.size() > 0;
    con_rx_data  = rxq.size() > 0 ? rxq[0] : 8'h00;
  end

  // behavioural reference model
  logic m_busy, m_we, m_txb, m_full, m_brk, m_rst, m_csr;
  logic [31:0] m_addr, m_cval;
  logic [7:0] m_wd, m_mb, m_txd, m_rxd;
  logic [4:0] m_cidx;
  logic [7:0] q[$];
  function automatic int need(logic [3:0] o);
    case (o)
      4'd1: return 5;
      4'd2: return 6;
      4'd4: return 2;
      default: return 6;
    endcase
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_we = 0; m_txb = 0; m_full = 0; m_brk = 0; m_rst = 0; m_csr = 0;
      m_addr = 0; m_cval = 0; m_wd = 0; m_mb = 0; m_txd = 0; m_rxd = 0; m_cidx = 0;
      q.delete();
    end else begin
      logic ob, otx, ofull;
      logic [2:0] ch;
      logic [7:0] b;
      ob = m_busy; otx = m_txb; ofull = m_full;
      ch = host_wdata[2:0]; b = host_wdata[10:3];
      m_brk = 0; m_rst = 0; m_csr = 0;
      if (ob && mem_ack) begin
        if (!m_we) m_mb = mem_rdata;
        m_addr++; m_busy = 0;
      end
      if (host_wr && ch == 0 && !ob) begin
        if (q.size() == 0) begin
          case (b[7:4])
            4'd3: begin m_we = 0; m_busy = 1; end
            4'd6: m_brk = 1;
            4'd7: m_rst = 1;
            4'd1, 4'd2, 4'd4, 4'd5: q.push_back(b);
            default: ;
          endcase
        end else q.push_back(b);
        if (q.size() > 0 && q.size() == need(q[0][7:4])) begin
          case (q[0][7:4])
            4'd1: begin m_addr = {q[1], q[2], q[3], q[4]}; m_we = 0; m_busy = 1; end
            4'd2: begin m_addr = {q[1], q[2], q[3], q[4]}; m_wd = q[5]; m_we = 1; m_busy = 1; end
            4'd4: begin m_wd = q[1]; m_we = 1; m_busy = 1; end
            default: begin m_csr = 1; m_cval = {q[1], q[2], q[3], q[4]}; m_cidx = q[5][4:0]; end
          endcase
          q.delete();
        end
      end
      if (otx && con_tx_ready) m_txb = 0;
      if (host_wr && ch == 1 && !otx) begin m_txb = 1; m_txd = b; end
      if (!ofull && con_rx_valid) begin m_full = 1; m_rxd = con_rx_data; end
      if (host_wr && ch == 2 && ofull) m_full = 0;
    end
  end

  // per-cycle comparison and event monitors
  int nreq = 0, nbrk = 0, nrst = 0, ncsr = 0;
  logic prev_req = 1'b0;
  logic [31:0] last_req_addr = '0, last_cval = '0;
  logic [4:0] last_cidx = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy/req", mem_req, m_busy);
      if (m_busy) begin
        chk("R4 addr", mem_addr, m_addr);
        chk("R3 we", mem_we, m_we);
        if (m_we) chk("R3 wdata", mem_wdata, m_wd);
      end
      chk("R10 readback", host_rdata, {m_full ? m_rxd : m_mb, m_busy, m_txb, m_full});
      chk("R5 csr_stb", csr_stb, m_csr);
      if (m_csr) chk("R5 csr", {csr_idx, csr_val}, {m_cidx, m_cval});
      chk("R6 brk", brk_pulse, m_brk);
      chk("R6 rst", rst_pulse, m_rst);
      chk("R8 tx_valid", con_tx_valid, m_txb);
      if (m_txb) chk("R8 tx_data", con_tx_data, m_txd);
      chk("R9 pop", con_rx_pop, !m_full && con_rx_valid);
      if (mem_req && !prev_req) begin nreq++; last_req_addr = mem_addr; end
      if (brk_pulse) nbrk++;
      if (rst_pulse) nrst++;
      if (csr_stb) begin ncsr++; last_cidx = csr_idx; last_cval = csr_val; end
    end
    prev_req = mem_req;
  end

  task automatic hw(logic [2:0] ch, logic [7:0] b);
    @(posedge clk); #1; host_wr = 1'b1; host_wdata = {b, ch};
    @(posedge clk); #1; host_wr = 1'b0;
  endtask
  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (host_rdata[2] && n < 200) begin @(negedge clk); n++; end
    chk("R2 busy falls", host_rdata[2], 1'b0);
  endtask
  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int b0, r0, q0, c0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", host_rdata, 11'd0);
    chk("R1 outs", {mem_req, con_tx_valid, csr_stb, brk_pulse, rst_pulse}, 5'd0);

    ack_delay = 3;
    hw(0, 8'h10); hw(0, 8'h12); hw(0, 8'h34); hw(0, 8'h56); hw(0, 8'h78);
    @(negedge clk);
    chk("R2 req", {mem_req, mem_we, host_rdata[2]}, 3'b101);
    chk("R2 addr", mem_addr, 32'h12345678);
    wait_idle();
    chk("R2 data", host_rdata[10:3], 8'hDD);

    hw(0, 8'h30); @(negedge clk);
    chk("R4 read-next addr", mem_addr, 32'h12345679);
    wait_idle();
    chk("R4 read-next data", host_rdata[10:3], 8'hDC);

    hw(0, 8'h20); hw(0, 8'h00); hw(0, 8'h00); hw(0, 8'h00); hw(0, 8'h10); hw(0, 8'h3C);
    @(negedge clk);
    chk("R3 write", {mem_we, mem_addr, mem_wdata}, {1'b1, 32'h10, 8'h3C});
    wait_idle();
    chk("R3 data kept", host_rdata[10:3], 8'hDC);
    hw(0, 8'h40); hw(0, 8'h4D); @(negedge clk);
    chk("R4 write-next", {mem_we, mem_addr, mem_wdata}, {1'b1, 32'h11, 8'h4D});
    wait_idle();

    c0 = ncsr;
    hw(0, 8'h50); hw(0, 8'hDE); hw(0, 8'hAD); hw(0, 8'hBE); hw(0, 8'hEF); hw(0, 8'h23);
    cyc(2);
    chk("R5 count", ncsr - c0, 1);
    chk("R5 value", {last_cidx, last_cval}, {5'd3, 32'hDEADBEEF});

    b0 = nbrk; r0 = nrst;
    hw(0, 8'h60); hw(0, 8'h70); cyc(2);
    chk("R6 break", nbrk - b0, 1);
    chk("R6 reset", nrst - r0, 1);

    ack_delay = 20; b0 = nbrk;
    hw(0, 8'h30); hw(0, 8'h60); hw(0, 8'h10);
    wait_idle();
    chk("R7 ignored break", nbrk - b0, 0);
    chk("R7 data", host_rdata[10:3], 8'h12 ^ 8'hA5);
    hw(0, 8'h30); @(negedge clk);
    chk("R7 addr intact", mem_addr, 32'h13);
    wait_idle();

    ack_delay = 1; b0 = nbrk; r0 = nrst; q0 = nreq;
    hw(3, 8'h60); hw(5, 8'h70); hw(7, 8'h10); hw(6, 8'h30); cyc(3);
    chk("R12 no effect", {nbrk - b0, nrst - r0, nreq - q0}, 96'd0);
    chk("R12 readback", host_rdata, {8'h13 ^ 8'hA5, 3'b000});

    q0 = nreq;
    hw(0, 8'h10); hw(0, 8'h01); hw(0, 8'h02); hw(0, 8'h00); hw(0, 8'h00);
    wait_idle();
    chk("R11 completion", {nreq - q0, last_req_addr}, {32'd1, 32'h01020000});
    b0 = nbrk;
    hw(0, 8'h00); hw(0, 8'h00); hw(0, 8'h00); hw(0, 8'h80); hw(0, 8'hF0); cyc(3);
    chk("R11 idle no-op", nreq - q0, 1);
    hw(0, 8'h30); wait_idle();
    chk("R11 new command", last_req_addr, 32'h01020001);

    hw(1, 8'h41); @(negedge clk);
    chk("R8 tx flag", {host_rdata[1], con_tx_data}, {1'b1, 8'h41});
    hw(1, 8'h42); cyc(2);
    chk("R8 busy write ignored", {con_tx_valid, con_tx_data}, {1'b1, 8'h41});
    @(posedge clk); #1 con_tx_ready = 1'b1;
    cyc(1); #1 con_tx_ready = 1'b0;
    @(negedge clk);
    chk("R8 tx released", host_rdata[1], 1'b0);
    hw(1, 8'h55); @(negedge clk);
    chk("R8 second byte", con_tx_data, 8'h55);
    @(posedge clk); #1 con_tx_ready = 1'b1;
    cyc(2); #1 con_tx_ready = 1'b0;

    inj_byte = 8'h99; inj_req++; cyc(3);
    chk("R9 rx flag", {host_rdata[10:3], host_rdata[0]}, {8'h99, 1'b1});
    inj_byte = 8'h77; inj_req++; cyc(3);
    chk("R9 held", host_rdata[10:3], 8'h99);
    hw(2, 8'h00); cyc(2);
    chk("R9 next byte", {host_rdata[10:3], host_rdata[0]}, {8'h77, 1'b1});
    hw(2, 8'h00); @(negedge clk);
    chk("R10 bus byte back", host_rdata, {8'h01 ^ 8'hA5, 3'b000});

    ack_delay = 2; ackinj_req++;
    hw(0, 8'h10); hw(0, 8'h00); hw(0, 8'h00); hw(0, 8'h00); hw(0, 8'h20);
    wait_idle(); cyc(1);
    chk("R10 same cycle rx wins", host_rdata, {8'hC3, 3'b001});
    hw(2, 8'h00); @(negedge clk);
    chk("R10 read byte", host_rdata, {8'h85, 3'b000});

    cyc(4);
    finish_run();
  end
endmodule